// File: doc/BRIEF.md
# Microcoded Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. The arithmetic is done by a small datapath: two working registers, a result register, a comparator and a subtractor whose inputs can be swapped. The datapath is driven by a microprogram held in a seven-word control store rather than by a hard-wired state machine.

Each stored word holds the datapath strobes together with a sequencer operation, a condition select and a branch address. A sequencer works out the next control-store address each cycle from the registered word and the live status flags. The word at that address is loaded into the microinstruction register on the next clock edge.

The caller places the operands on `x_i` and `y_i` and raises `start_i` for at least one clock. The operands must stay stable until the load cycle has passed. When the result is ready, `z_o` holds the GCD and `eoc_o` is high. Both keep their values until the next run loads new operands.

Top module: `gcd_mcode_unit`

## Requirements
- R1: While `rst_ni` is low, `z_o` is 0, `eoc_o` is 0 and the control address is 0.
- R2: While the control address is 0 and `start_i` is low, the address stays at 0 and `z_o`/`eoc_o` do not change.
- R3: The second rising edge after `start_i` is sampled high loads `x_i` and `y_i` into the working registers and clears `eoc_o`.
- R4: For any two operands, each nonzero, `z_o` equals their greatest common divisor when `eoc_o` rises.
- R5: If the operands are equal, `eoc_o` is high four clock edges after the edge that samples `start_i`.
- R6: If one operand is zero, `z_o` is the other operand. If both are zero, `z_o` is 0. In all of these cases `eoc_o` rises after the same four edges as in R5.
- R7: Once `eoc_o` is high, `eoc_o` and `z_o` hold their values until a new start loads operands.
- R8: The sequencer operation codes are 2'b00 (go to the current address plus one), 2'b01 (go to the branch address if the selected condition is true, else plus one) and 2'b10 (go to the branch address).
- R9: A reduction step always subtracts the smaller working operand from the larger one. A working register is never loaded with a difference unless it holds the larger value.
- R10: The condition select codes are 2'b00 (start low), 2'b01 (operands equal or either is zero) and 2'b10 (first operand greater than the second). A conditional branch is taken exactly when the selected condition is true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a computation |
| x_i | input | DATA_W | First operand |
| y_i | input | DATA_W | Second operand |
| z_o | output | DATA_W | GCD result |
| eoc_o | output | 1 | End of computation |

## Verification
The bench builds the block with the default operand width of 8 bits. At this width, a pair such as 255 and 1, which needs the longest chain of subtractions, finishes in under a thousand cycles. This makes it possible to run the extreme operands, both orders of each pair, all the zero cases and a large set of random pairs. The cycle count to `eoc_o` is checked exactly for the short paths: equal operands and the zero rule.

// File: rtl/gcd_mc_pkg.sv
package gcd_mc_pkg;
  localparam int UADDR_W    = 3;
  localparam int UROM_WORDS = 7;

  typedef enum logic [1:0] {
    SEQ_ADV  = 2'b00,
    SEQ_CJMP = 2'b01,
    SEQ_JMP  = 2'b10,
    SEQ_RSV  = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    CND_IDLE = 2'b00,  // start low
    CND_DONE = 2'b01,  // equal or a zero operand
    CND_GT   = 2'b10,  // first > second
    CND_NONE = 2'b11
  } cond_e;

  typedef struct packed {
    logic                r1_from_diff;
    logic                r2_from_diff;
    logic                sub_swap;
    logic                ld_r1;
    logic                ld_r2;
    logic                ld_res;
    logic                eoc_clr;
    logic                eoc_set;
    seq_op_e             op;
    cond_e               cnd;
    logic [UADDR_W-1:0]  ba;
  } uword_t;
endpackage

// File: rtl/gcd_mc_rom.sv
module gcd_mc_rom
  import gcd_mc_pkg::*;
(
  input  logic [UADDR_W-1:0] addr_i,
  output uword_t             word_o
);
  function automatic uword_t seq_only(seq_op_e op, cond_e c, logic [UADDR_W-1:0] ba);
    uword_t w;
    w     = '0;
    w.op  = op;
    w.cnd = c;
    w.ba  = ba;
    return w;
  endfunction

  always_comb begin
    word_o = seq_only(SEQ_JMP, CND_NONE, UADDR_W'(0));
    unique case (addr_i)
      3'd0: word_o = seq_only(SEQ_CJMP, CND_IDLE, 3'd0);
      3'd1: begin
        word_o         = seq_only(SEQ_ADV, CND_NONE, 3'd0);
        word_o.ld_r1   = 1'b1;
        word_o.ld_r2   = 1'b1;
        word_o.eoc_clr = 1'b1;
      end
      3'd2: word_o = seq_only(SEQ_CJMP, CND_DONE, 3'd6);
      3'd3: word_o = seq_only(SEQ_CJMP, CND_GT, 3'd5);
      3'd4: begin  // second is larger: r2 := r2 - r1
        word_o              = seq_only(SEQ_JMP, CND_NONE, 3'd2);
        word_o.sub_swap     = 1'b1;
        word_o.r2_from_diff = 1'b1;
        word_o.ld_r2        = 1'b1;
      end
      3'd5: begin  // first is larger: r1 := r1 - r2
        word_o              = seq_only(SEQ_JMP, CND_NONE, 3'd2);
        word_o.r1_from_diff = 1'b1;
        word_o.ld_r1        = 1'b1;
      end
      3'd6: begin
        word_o         = seq_only(SEQ_JMP, CND_NONE, 3'd0);
        word_o.ld_res  = 1'b1;
        word_o.eoc_set = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gcd_mc_seq.sv
module gcd_mc_seq
  import gcd_mc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  uword_t             uir_i,
  input  logic               start_i,
  input  logic               done_i,
  input  logic               gt_i,
  output logic [UADDR_W-1:0] upc_o,
  output logic [UADDR_W-1:0] nxt_o
);
  logic [UADDR_W-1:0] upc_q;
  logic               cond;

  always_comb begin
    unique case (uir_i.cnd)
      CND_IDLE: cond = ~start_i;
      CND_DONE: cond = done_i;
      CND_GT:   cond = gt_i;
      default:  cond = 1'b0;
    endcase
  end

  always_comb begin
    unique case (uir_i.op)
      SEQ_CJMP: nxt_o = cond ? uir_i.ba : upc_q + 1'b1;
      SEQ_JMP:  nxt_o = uir_i.ba;
      default:  nxt_o = upc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= nxt_o;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/gcd_mc_dp.sv
module gcd_mc_dp
  import gcd_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uword_t            uir_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] r1_o,
  output logic [DATA_W-1:0] r2_o,
  output logic [DATA_W-1:0] z_o,
  output logic              eoc_o,
  output logic              done_o,
  output logic              gt_o
);
  logic [DATA_W-1:0] r1_q, r2_q, res_q, sub_a, sub_b, diff, res_d;
  logic              eoc_q;

  assign sub_a = uir_i.sub_swap ? r2_q : r1_q;
  assign sub_b = uir_i.sub_swap ? r1_q : r2_q;
  assign diff  = sub_a - sub_b;

  assign done_o = (r1_q == r2_q) || (r1_q == '0) || (r2_q == '0);
  assign gt_o   = r1_q > r2_q;
  assign res_d  = (r1_q != '0) ? r1_q : r2_q;  // zero rule

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q  <= '0;
      r2_q  <= '0;
      res_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      if (uir_i.ld_r1)  r1_q  <= uir_i.r1_from_diff ? diff : x_i;
      if (uir_i.ld_r2)  r2_q  <= uir_i.r2_from_diff ? diff : y_i;
      if (uir_i.ld_res) res_q <= res_d;
      if (uir_i.eoc_set)      eoc_q <= 1'b1;
      else if (uir_i.eoc_clr) eoc_q <= 1'b0;
    end
  end

  assign r1_o  = r1_q;
  assign r2_o  = r2_q;
  assign z_o   = res_q;
  assign eoc_o = eoc_q;
endmodule

// File: rtl/gcd_mcode_unit.sv
module gcd_mcode_unit
  import gcd_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] z_o,
  output logic              eoc_o
);
  logic [UADDR_W-1:0] upc_w, nxt_w;
  uword_t             rom_w, uir_q, rst_word;
  logic [DATA_W-1:0]  r1_w, r2_w;
  logic               done_w, gt_w;

  gcd_mc_rom u_rom (.addr_i(nxt_w), .word_o(rom_w));

  gcd_mc_rom u_rom_rst (.addr_i(UADDR_W'(0)), .word_o(rst_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uir_q <= rst_word;
    else         uir_q <= rom_w;
  end

  gcd_mc_seq u_seq (
    .clk_i, .rst_ni, .uir_i(uir_q), .start_i,
    .done_i(done_w), .gt_i(gt_w), .upc_o(upc_w), .nxt_o(nxt_w)
  );

  gcd_mc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni, .uir_i(uir_q), .x_i, .y_i,
    .r1_o(r1_w), .r2_o(r2_w), .z_o, .eoc_o, .done_o(done_w), .gt_o(gt_w)
  );
endmodule

// File: rtl/gcd_mcode_chk.sv
module gcd_mcode_chk
  import gcd_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               eoc_o,
  input logic [DATA_W-1:0]  z_o,
  input logic [UADDR_W-1:0] upc,
  input uword_t             uir,
  input logic [DATA_W-1:0]  r1,
  input logic [DATA_W-1:0]  r2
);
  always_comb begin
    if (!rst_ni) a_r1_reset_state: assert (upc == '0 && !eoc_o && z_o == '0);
  end

  a_r2_idle_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc == '0 && !start_i) |=> (upc == '0 && $stable(z_o) && $stable(eoc_o)));

  a_r3_eoc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uir.eoc_clr |=> !eoc_o);

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && !uir.eoc_clr) |=> (eoc_o && $stable(z_o)));

  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.op == SEQ_ADV) |=> (upc == UADDR_W'($past(upc) + 1'b1)));

  a_r8_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.op == SEQ_JMP) |=> (upc == $past(uir.ba)));

  a_r9_sub_r1_larger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.ld_r1 && uir.r1_from_diff) |-> (r1 > r2));

  a_r9_sub_r2_larger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.ld_r2 && uir.r2_from_diff) |-> (r2 > r1));

  a_r10_gt_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.op == SEQ_CJMP && uir.cnd == CND_GT && r1 > r2) |=> (upc == $past(uir.ba)));

  a_r10_gt_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uir.op == SEQ_CJMP && uir.cnd == CND_GT && r1 <= r2)
      |=> (upc == UADDR_W'($past(upc) + 1'b1)));
endmodule

bind gcd_mcode_unit gcd_mcode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .eoc_o(eoc_o), .z_o(z_o),
  .upc(upc_w), .uir(uir_q), .r1(r1_w), .r2(r2_w)
);

// File: tb/sim_gcd_mcode_unit.sv
`timescale 1ns/1ps
module sim_gcd_mcode_unit;
  localparam int DATA_W = 8;
  localparam int RUN_LIMIT = 4000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] x = '0, y = '0;
  logic [DATA_W-1:0] z;
  logic              eoc;
  int                n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  gcd_mcode_unit #(.DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_i(x), .y_i(y), .z_o(z), .eoc_o(eoc)
  );

  function automatic int ref_gcd(int a, int b);
    int t;
    if (a == 0) return b;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns cycles from the start-sampling edge to eoc seen high
  task automatic run_pair(int a, int b, string req, output int cyc);
    @(negedge clk);
    x = DATA_W'(a); y = DATA_W'(b); start = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (cyc == 2) check(eoc == 1'b0, "R3 eoc cleared on load", int'(eoc), 0);
      if (cyc >= 2 && eoc) break;
      if (cyc > RUN_LIMIT) begin
        check(1'b0, "R4 run timeout", cyc, RUN_LIMIT);
        break;
      end
    end
    check(int'(z) == ref_gcd(a, b), req, int'(z), ref_gcd(a, b));
  endtask

  task automatic t_reset();
    #5;
    check(z == '0, "R1 z in reset", int'(z), 0);
    check(eoc == 1'b0, "R1 eoc in reset", int'(eoc), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    repeat (10) @(negedge clk);
    check(eoc == 1'b0 && z == '0, "R2 idle no change", int'(z), 0);
  endtask

  task automatic t_basic();
    int c;
    run_pair(12, 18, "R4 12,18", c);
    run_pair(35, 14, "R4 35,14", c);
    run_pair(17, 5, "R4 17,5", c);
    run_pair(255, 1, "R4 255,1", c);
    run_pair(1, 255, "R4 1,255", c);
    run_pair(128, 64, "R4 128,64", c);
    run_pair(221, 187, "R4 221,187", c);
  endtask

  task automatic t_equal();
    int c;
    run_pair(9, 9, "R5 equal result", c);
    check(c == 4, "R5 equal latency", c, 4);
  endtask

  task automatic t_zero();
    int c;
    run_pair(0, 7, "R6 x zero", c);
    check(c == 4, "R6 x zero latency", c, 4);
    run_pair(7, 0, "R6 y zero", c);
    check(c == 4, "R6 y zero latency", c, 4);
    run_pair(0, 0, "R6 both zero", c);
    check(c == 4, "R6 both zero latency", c, 4);
  endtask

  task automatic t_hold();
    int c;
    logic [DATA_W-1:0] zk;
    run_pair(24, 36, "R7 setup", c);
    zk = z;
    @(negedge clk);
    x = 8'd3; y = 8'd5;
    repeat (12) @(negedge clk);
    check(eoc == 1'b1, "R7 eoc held", int'(eoc), 1);
    check(z == zk, "R7 z held", int'(z), int'(zk));
  endtask

  task automatic t_branches();
    int c;
    // exercises both conditional branch outcomes and both subtract words (R8 R9 R10)
    run_pair(100, 3, "R10 gt path", c);
    run_pair(3, 100, "R9 second larger path", c);
    run_pair(60, 48, "R8 mixed path", c);
  endtask

  task automatic t_random();
    int c;
    for (int i = 0; i < 150; i++) begin
      int a, b;
      a = int'($urandom_range(1, 255));
      b = int'($urandom_range(1, 255));
      run_pair(a, b, "R4 random", c);
    end
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_equal();
    t_zero();
    t_hold();
    t_branches();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule